// File: doc/BRIEF.md
# Dual-Half Carry/Borrow Loop Filter

This block is the sequential filter stage of an all-digital phase tracking loop. It has two modulo-K counters that are kept apart: an ascending half and a descending half. A one-bit direction input, normally the phase comparator's output, decides which half moves on each clock where the enable is high. The other half keeps its value. When the ascending half completes K steps it raises a one-clock carry pulse, which is meant to drive a cycle-insertion request. When the descending half completes K steps it raises a one-clock borrow pulse, which is meant to drive a cycle-removal request.

A single up/down counter cancels up steps against down steps. Here neither half ever undoes the other's progress. A burst of wrong-direction samples therefore only delays the opposite half; it never erases it. K is a parameter. It must be a power of two and at least 2, and elaboration stops with an error for any other value.

Top module: `kfilt_carry_borrow`

## Requirements
- R1: When rst_ni is low, carry_o and borrow_o are 0, the ascending half is set to 0 and the descending half to K-1. After reset, the K-th ascending step makes a carry and the K-th descending step makes a borrow.
- R2: While en_i is 0, neither half moves and neither pulse is raised, whatever the value of dn_up_i.
- R3: A clock edge with en_i=1 and dn_up_i=0 advances the ascending half only. The edge that completes its K-th step since its last wrap sets carry_o to 1 for the clock cycle after that edge.
- R4: A clock edge with en_i=1 and dn_up_i=1 advances the descending half only. The edge that completes its K-th step since its last wrap sets borrow_o to 1 for the clock cycle after that edge.
- R5: The half that is not selected keeps its count. When the two directions are interleaved, each half wraps after exactly K of its own steps, and the steps of the other half have no effect on it.
- R6: carry_o and borrow_o are each exactly one clock cycle wide, and they are never 1 in the same cycle.
- R7: Under steady stepping in one direction, that half's pulse repeats every K enabled steps without drift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Step enable for the selected half |
| dn_up_i | input | 1 | Direction: 0 selects the ascending half, 1 the descending half |
| carry_o | output | 1 | One-cycle pulse when the ascending half wraps |
| borrow_o | output | 1 | One-cycle pulse when the descending half wraps |

## Verification
The count values inside the block are only visible through where the pulses fall. A corrupted or wrongly reset count in either half therefore shows up as a pulse one or more steps early or late, at the latest within K steps in that direction. A half that moves when it is not selected shifts its next wrap. This is caught by interleaved runs that stop just short of a wrap and then switch direction. A pulse that is too wide, appears without an enable, or comes together with the other pulse is visible on the very next clock.

// File: rtl/kfilt_pkg.sv
package kfilt_pkg;
  typedef enum logic {
    DIR_ASC  = 1'b0,
    DIR_DESC = 1'b1
  } dir_e;

  typedef struct packed {
    logic carry;
    logic borrow;
  } wrap_t;
endpackage

// File: rtl/kfilt_half_cnt.sv
module kfilt_half_cnt #(
  parameter int unsigned K_MOD = 8,
  parameter bit          DESC  = 1'b0,
  localparam int unsigned CW   = $clog2(K_MOD)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  output logic          wrap_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] START = DESC ? CW'(K_MOD - 1) : '0;
  localparam logic [CW-1:0] TERM  = DESC ? '0 : CW'(K_MOD - 1);

  logic [CW-1:0] cnt_q;

  // power-of-two modulus: natural overflow wraps the count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= START;
    else if (step_i) cnt_q <= DESC ? cnt_q - 1'b1 : cnt_q + 1'b1;
  end

  assign wrap_o = step_i && (cnt_q == TERM);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/kfilt_pulse_reg.sv
module kfilt_pulse_reg
  import kfilt_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  wrap_t wrap_i,
  output wrap_t wrap_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wrap_o <= '0;
    else         wrap_o <= wrap_i;
  end
endmodule

// File: rtl/kfilt_carry_borrow.sv
module kfilt_carry_borrow
  import kfilt_pkg::*;
#(
  parameter int unsigned K_MOD = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic dn_up_i,
  output logic carry_o,
  output logic borrow_o
);
  localparam int unsigned CW     = $clog2(K_MOD);
  localparam int unsigned NHALF  = 2;

  if (K_MOD < 2 || (K_MOD & (K_MOD - 1)) != 0) begin : g_bad_k
    $error("K_MOD must be a power of two and at least 2");
  end

  dir_e          dir;
  logic [NHALF-1:0] step;
  logic [NHALF-1:0] wrap;
  logic [CW-1:0]    cnt [NHALF];
  wrap_t            wrap_d, wrap_q;

  assign dir = dir_e'(dn_up_i);

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    localparam bit IS_DESC = (h == 1);
    assign step[h] = en_i && (dir == (IS_DESC ? DIR_DESC : DIR_ASC));

    kfilt_half_cnt #(
      .K_MOD(K_MOD),
      .DESC (IS_DESC)
    ) u_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .step_i(step[h]),
      .wrap_o(wrap[h]),
      .cnt_o (cnt[h])
    );
  end

  assign wrap_d.carry  = wrap[0];
  assign wrap_d.borrow = wrap[1];

  kfilt_pulse_reg u_pulse (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wrap_i(wrap_d),
    .wrap_o(wrap_q)
  );

  assign carry_o  = wrap_q.carry;
  assign borrow_o = wrap_q.borrow;
endmodule

// File: rtl/kfilt_carry_borrow_chk.sv
module kfilt_carry_borrow_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic dn_up_i,
  input logic carry_o,
  input logic borrow_o
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) reset_quiet_chk: assert (!carry_o && !borrow_o);
  end

  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!carry_o && !borrow_o));

  // R3
  carry_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && !dn_up_i) |=> !carry_o);

  // R4
  borrow_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && dn_up_i) |=> !borrow_o);

  // R6
  carry_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |=> !carry_o);

  // R6
  borrow_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    borrow_o |=> !borrow_o);

  // R6
  exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(carry_o && borrow_o));
endmodule

bind kfilt_carry_borrow kfilt_carry_borrow_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .dn_up_i (dn_up_i),
  .carry_o (carry_o),
  .borrow_o(borrow_o)
);

// File: tb/sim_kfilt_carry_borrow.sv
`timescale 1ns/1ps
module sim_kfilt_carry_borrow;
  localparam int K = 8;

  typedef struct {
    bit    c;
    bit    b;
    string tag;
  } exp_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0;
  logic dn_up_i = 1'b0;
  logic carry_o, borrow_o;

  int n_cmp = 0;
  int n_bad = 0;
  int up_m = 0;
  int dn_m = K - 1;
  bit finished = 1'b0;
  exp_t q[$];

  always #5 clk_i = ~clk_i;

  kfilt_carry_borrow #(.K_MOD(K)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .dn_up_i(dn_up_i),
    .carry_o(carry_o), .borrow_o(borrow_o)
  );

  // monitor: results settle after the edge that consumes the queued item
  always @(posedge clk_i) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (carry_o !== e.c || borrow_o !== e.b) begin
        n_bad++;
        $display("FAIL %s: carry/borrow=%b%b expected %b%b at %0t",
                 e.tag, carry_o, borrow_o, e.c, e.b, $time);
      end
    end
  end

  task automatic step(input bit en, input bit dn, input string tag);
    exp_t e;
    @(negedge clk_i);
    en_i = en;
    dn_up_i = dn;
    e.c = 1'b0;
    e.b = 1'b0;
    e.tag = tag;
    if (en && !dn) begin
      if (up_m == K - 1) begin up_m = 0; e.c = 1'b1; end
      else up_m++;
    end else if (en && dn) begin
      if (dn_m == 0) begin dn_m = K - 1; e.b = 1'b1; end
      else dn_m--;
    end
    q.push_back(e);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    en_i = 1'b0;
    q.delete();
    up_m = 0;
    dn_m = K - 1;
    #1;
    n_cmp++;
    if (carry_o !== 1'b0 || borrow_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: carry/borrow=%b%b expected 00 in reset", carry_o, borrow_o);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state, then first wraps after exactly K steps
    do_reset();
    for (int i = 0; i < K; i++) step(1, 0, "R1");
    for (int i = 0; i < K; i++) step(1, 1, "R1");
    // R2: idle with direction toggling, counts must hold
    for (int i = 0; i < K - 1; i++) step(1, 0, "R2");
    for (int i = 0; i < 20; i++) step(0, i[0], "R2");
    step(1, 0, "R2");
    // R3 and R7: steady ascending stepping
    for (int i = 0; i < 3 * K; i++) step(1, 0, "R7");
    // R4 and R7: steady descending stepping
    for (int i = 0; i < 3 * K; i++) step(1, 1, "R4");
    // R5: interleave, each half stops short of its wrap
    for (int i = 0; i < K - 1; i++) step(1, 0, "R5");
    for (int i = 0; i < K - 1; i++) step(1, 1, "R5");
    step(1, 0, "R5");
    step(1, 1, "R5");
    for (int i = 0; i < 4 * K; i++) step(1, i[0], "R5");
    // R3: single step with gaps
    for (int i = 0; i < 2 * K; i++) begin
      step(1, 0, "R3");
      step(0, 0, "R3");
    end
    // R6: random mix
    for (int i = 0; i < 400; i++) step(($urandom % 4) != 0, $urandom % 2, "R6");
    // R1: reset in mid-count restores start values
    for (int i = 0; i < 3; i++) step(1, 0, "R1");
    for (int i = 0; i < 5; i++) step(1, 1, "R1");
    do_reset();
    for (int i = 0; i < K; i++) step(1, 0, "R1");
    for (int i = 0; i < K; i++) step(1, 1, "R1");
    step(0, 0, "R1");
    @(negedge clk_i);
    @(negedge clk_i);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule